// File: doc/BRIEF.md
# Dual-Field Modular and Wide Adder

This block is a purely combinational adder/subtracter that serves both prime-field and binary-field residue datapaths. It holds two r-bit carry-lookahead adders. A field-select input picks one of two behaviours. In binary-field mode every carry is forced to zero, so the sum of two polynomials is their bitwise XOR. In integer mode the block works as one of two kinds of unit. As a modular adder/subtracter, it reduces against an r-bit modulus. As a plain wide adder/subtracter, the two halves are chained into a single 2r-bit datapath.

Each adder uses three levels of 4-bit lookahead generator groups. In modular mode, the lower adder forms a±b. The upper adder forms that value corrected by the modulus, and the output keeps whichever of the two lies in [0, m). In binary-field mode the upper adder produces the result, with its carries killed.

Top module: `dfmn_adder`

## Requirements
- R1: With fsel_i=0 (binary field), res_o equals a_i[r-1:0] XOR b_i[r-1:0], and res_o[2r-1:r] is zero.
- R2: With fsel_i=0, the inputs sub_i, mod_i, m_i and a_i/b_i bits [2r-1:r] have no effect on res_o.
- R3: With fsel_i=1, mod_i=0 and sub_i=0, res_o equals (a_i + b_i) mod 2^(2r).
- R4: With fsel_i=1, mod_i=0 and sub_i=1, res_o equals (a_i - b_i) mod 2^(2r).
- R5: In the wide integer mode, a carry or borrow out of bit r-1 reaches bit r. For example, 0x0000_FFFF + 1 gives 0x0001_0000 for r=16.
- R6: With fsel_i=1, mod_i=1, sub_i=0, and a, b < m, res_o equals (a + b) mod m, and the upper half is zero. A sum equal to m gives 0.
- R7: With fsel_i=1, mod_i=1, sub_i=1, and a, b < m, res_o equals (a - b) mod m. Equal operands give 0.
- R8: A modular sum is still reduced correctly when a + b is 2^r or more. For example, with m = 0xFFFF, 0xFFFE + 0xFFFE gives 0xFFFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fsel_i | input | 1 | 0 = binary field (carry-free), 1 = integer |
| sub_i | input | 1 | 1 = subtract (integer mode only) |
| mod_i | input | 1 | 1 = modular against m_i, 0 = plain 2r-bit (integer mode only) |
| a_i | input | 2*R_W | First operand; only the low r bits are used in the binary-field and modular modes |
| b_i | input | 2*R_W | Second operand; only the low r bits are used in the binary-field and modular modes |
| m_i | input | R_W | Modulus for modular mode |
| res_o | output | 2*R_W | Result word |

## Verification
The directed vectors cover the binary-field XOR with the other controls and the upper operand bits set to arbitrary values. They show whether a carry leaks through the kill gating and whether an ignored control changes the result. The wide mode is driven with values that carry across the half boundary, borrow across it, and wrap at 2^(2r). These show whether the two halves are really chained. The modular vectors include sums equal to m, sums above 2^r, equal-operand differences and m = 1. These expose a wrong selection between the corrected and uncorrected sums. Random operands in every mode are then checked against a behavioural reference model on every clock.

// File: rtl/dfmn_pkg.sv
package dfmn_pkg;
  typedef enum logic [1:0] {
    OP_GF   = 2'd0,
    OP_WIDE = 2'd1,
    OP_MOD  = 2'd2
  } op_e;

  function automatic op_e decode_op(input logic fsel, input logic modsel);
    if (!fsel)  return OP_GF;
    if (modsel) return OP_MOD;
    return OP_WIDE;
  endfunction
endpackage

// File: rtl/dfmn_lag4.sv
// 4-bit lookahead group: carries into each position plus group generate/propagate
module dfmn_lag4 (
  input  logic [3:0] g_i,
  input  logic [3:0] p_i,
  input  logic       c_i,
  output logic [3:0] c_o,
  output logic       g_o,
  output logic       p_o
);
  assign c_o[0] = c_i;
  assign c_o[1] = g_i[0] | (p_i[0] & c_i);
  assign c_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & c_i);
  assign c_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
                | (p_i[2] & p_i[1] & p_i[0] & c_i);
  assign g_o = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
             | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
  assign p_o = &p_i;
endmodule

// File: rtl/dfmn_cla.sv
// Three-level carry-lookahead adder with carry-kill gating (cen_i=0 -> XOR)
module dfmn_cla #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         cen_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NG2 = (W + 15) / 16;
  localparam int unsigned NG1 = 4 * NG2;
  localparam int unsigned PW  = 4 * NG1;

  logic [PW-1:0]  g, p, c;
  logic [NG1-1:0] g1, p1, c1;
  logic [3:0]     g2, p2, c2;
  logic           g3, p3, cin_k;

  // carry kill: AND gates on generates and carry-in
  assign g[W-1:0] = a_i & b_i & {W{cen_i}};
  assign p[W-1:0] = a_i ^ b_i;
  assign cin_k    = cin_i & cen_i;

  generate
    if (PW > W) begin : g_pad
      assign g[PW-1:W] = '0;
      assign p[PW-1:W] = '1;
    end
    for (genvar i = 0; i < NG1; i++) begin : g_lvl1
      dfmn_lag4 u_lag (
        .g_i(g[4*i +: 4]), .p_i(p[4*i +: 4]), .c_i(c1[i]),
        .c_o(c[4*i +: 4]), .g_o(g1[i]), .p_o(p1[i])
      );
    end
    for (genvar j = 0; j < NG2; j++) begin : g_lvl2
      dfmn_lag4 u_lag (
        .g_i(g1[4*j +: 4]), .p_i(p1[4*j +: 4]), .c_i(c2[j]),
        .c_o(c1[4*j +: 4]), .g_o(g2[j]), .p_o(p2[j])
      );
    end
    if (NG2 < 4) begin : g_pad2
      assign g2[3:NG2] = '0;
      assign p2[3:NG2] = '1;
    end
  endgenerate

  dfmn_lag4 u_lvl3 (
    .g_i(g2), .p_i(p2), .c_i(cin_k), .c_o(c2), .g_o(g3), .p_o(p3)
  );

  assign sum_o  = p[W-1:0] ^ c[W-1:0];
  assign cout_o = g3 | (p3 & cin_k);
endmodule

// File: rtl/dfmn_adder.sv
module dfmn_adder
  import dfmn_pkg::*;
#(
  parameter int unsigned R_W = 16
) (
  input  logic             fsel_i,
  input  logic             sub_i,
  input  logic             mod_i,
  input  logic [2*R_W-1:0] a_i,
  input  logic [2*R_W-1:0] b_i,
  input  logic [R_W-1:0]   m_i,
  output logic [2*R_W-1:0] res_o
);
  localparam int unsigned DW = 2 * R_W;

  op_e            op;
  logic           inv;
  logic [R_W-1:0] a_lo, b_lo, lo_sum, hi_a, hi_b, hi_sum;
  logic           lo_co, hi_cin, hi_cen, hi_co;
  logic           keep_lo;

  assign op   = decode_op(fsel_i, mod_i);
  assign inv  = fsel_i & sub_i;
  assign a_lo = a_i[R_W-1:0];
  assign b_lo = b_i[R_W-1:0];

  // lower adder: a +/- b on the low half
  dfmn_cla #(.W(R_W)) u_lo (
    .a_i(a_lo), .b_i(b_lo ^ {R_W{inv}}), .cin_i(inv), .cen_i(1'b1),
    .sum_o(lo_sum), .cout_o(lo_co)
  );

  // upper adder operand steering per mode
  always_comb begin
    hi_a   = a_lo;
    hi_b   = b_lo;
    hi_cin = 1'b0;
    hi_cen = 1'b0;
    unique case (op)
      OP_WIDE: begin
        hi_a   = a_i[DW-1:R_W];
        hi_b   = b_i[DW-1:R_W] ^ {R_W{inv}};
        hi_cin = lo_co;
        hi_cen = 1'b1;
      end
      OP_MOD: begin
        hi_a   = lo_sum;
        hi_b   = sub_i ? m_i : ~m_i;   // add: s - m, sub: s + m
        hi_cin = ~sub_i;
        hi_cen = 1'b1;
      end
      default: ;
    endcase
  end

  dfmn_cla #(.W(R_W)) u_hi (
    .a_i(hi_a), .b_i(hi_b), .cin_i(hi_cin), .cen_i(hi_cen),
    .sum_o(hi_sum), .cout_o(hi_co)
  );

  // add: keep a+b only if it neither overflowed nor reached m
  // sub: keep a-b only if no borrow occurred
  assign keep_lo = sub_i ? lo_co : ~(lo_co | hi_co);

  always_comb begin
    unique case (op)
      OP_WIDE: res_o = {hi_sum, lo_sum};
      OP_MOD:  res_o = {{R_W{1'b0}}, keep_lo ? lo_sum : hi_sum};
      default: res_o = {{R_W{1'b0}}, hi_sum};
    endcase
  end
endmodule

// File: rtl/dfmn_adder_chk.sv
module dfmn_adder_chk #(
  parameter int unsigned R_W = 16
) (
  input logic             fsel_i,
  input logic             sub_i,
  input logic             mod_i,
  input logic [2*R_W-1:0] a_i,
  input logic [2*R_W-1:0] b_i,
  input logic [R_W-1:0]   m_i,
  input logic [2*R_W-1:0] res_o
);
  logic [R_W-1:0] al, bl;
  assign al = a_i[R_W-1:0];
  assign bl = b_i[R_W-1:0];

  always_comb begin
    if (!$isunknown({fsel_i, sub_i, mod_i, a_i, b_i, m_i})) begin
      if (!fsel_i) begin
        // R1
        gf_xor_chk: assert (res_o == {{R_W{1'b0}}, al ^ bl});
      end
      if (fsel_i && !mod_i && !sub_i) begin
        // R3
        wide_add_chk: assert (res_o == a_i + b_i);
      end
      if (fsel_i && !mod_i && sub_i) begin
        // R4
        wide_sub_chk: assert (res_o == a_i - b_i);
      end
      if (fsel_i && mod_i && al < m_i && bl < m_i) begin
        // R6
        mod_range_chk: assert (res_o[2*R_W-1:R_W] == '0 && res_o[R_W-1:0] < m_i);
        if (sub_i) begin
          // R7
          mod_sub_chk: assert (al >= bl ? res_o[R_W-1:0] == al - bl
                                        : res_o[R_W-1:0] == al - bl + m_i);
        end
      end
    end
  end
endmodule

bind dfmn_adder dfmn_adder_chk #(.R_W(R_W)) u_chk (
  .fsel_i(fsel_i), .sub_i(sub_i), .mod_i(mod_i),
  .a_i(a_i), .b_i(b_i), .m_i(m_i), .res_o(res_o)
);

// File: tb/dfmn_adder_test.sv
`timescale 1ns/1ps
module dfmn_adder_test;
  localparam int unsigned R  = 16;
  localparam int unsigned DW = 2 * R;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          fsel, sub, modsel;
  logic [DW-1:0] a, b, res;
  logic [R-1:0]  m;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  dfmn_adder #(.R_W(R)) uut (
    .fsel_i(fsel), .sub_i(sub), .mod_i(modsel),
    .a_i(a), .b_i(b), .m_i(m), .res_o(res)
  );

  function automatic longint unsigned model(
    input bit f, input bit s, input bit md,
    input longint unsigned x, input longint unsigned y, input longint unsigned mm);
    longint unsigned xl, yl, mask;
    mask = (64'd1 << DW) - 1;
    xl = x & ((64'd1 << R) - 1);
    yl = y & ((64'd1 << R) - 1);
    if (!f) return xl ^ yl;
    if (!md) return s ? ((x - y) & mask) : ((x + y) & mask);
    if (s) return (xl >= yl) ? xl - yl : xl + mm - yl;
    return (xl + yl >= mm) ? xl + yl - mm : xl + yl;
  endfunction

  task automatic apply(input bit f, input bit s, input bit md,
                       input logic [DW-1:0] x, input logic [DW-1:0] y,
                       input logic [R-1:0] mm, input string req);
    longint unsigned exp;
    @(negedge clk);
    fsel = f; sub = s; modsel = md; a = x; b = y; m = mm;
    #5;
    exp = model(f, s, md, x, y, mm);
    checks++;
    if (res !== exp[DW-1:0]) begin
      errors++;
      $display("FAIL %s: got %h expected %h (f=%0b s=%0b md=%0b a=%h b=%h m=%h)",
               req, res, exp[DW-1:0], f, s, md, x, y, mm);
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    fsel = 0; sub = 0; modsel = 0; a = '0; b = '0; m = '0;
    // all-zero start state
    apply(0, 0, 0, 32'h0, 32'h0, 16'h0, "R1 zero");
    // R1 carry-free addition
    apply(0, 0, 0, 32'h0000_FFFF, 32'h0000_0001, 16'h0, "R1 no carry");
    apply(0, 0, 0, 32'h0000_A5A5, 32'h0000_FFFF, 16'h0, "R1 xor");
    // R2 ignored controls and upper bits
    apply(0, 1, 1, 32'hDEAD_1234, 32'hBEEF_00FF, 16'h7777, "R2 ignored");
    apply(0, 1, 0, 32'hFFFF_8000, 32'h1234_8000, 16'h0001, "R2 ignored");
    // R3 / R4 / R5 wide mode
    apply(1, 0, 0, 32'h1234_5678, 32'h0101_0101, 16'h0, "R3 add");
    apply(1, 0, 0, 32'h0000_FFFF, 32'h0000_0001, 16'h0, "R5 carry across");
    apply(1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0, "R3 wrap");
    apply(1, 1, 0, 32'h0001_0000, 32'h0000_0001, 16'h0, "R5 borrow across");
    apply(1, 1, 0, 32'h0000_0000, 32'h0000_0001, 16'h0, "R4 wrap");
    // R6 / R7 / R8 modular mode
    apply(1, 0, 1, 32'h0000_0003, 32'h0000_0004, 16'h000B, "R6 below m");
    apply(1, 0, 1, 32'h0000_0005, 32'h0000_0006, 16'h000B, "R6 equal m");
    apply(1, 0, 1, 32'h0000_0008, 32'h0000_0009, 16'h000B, "R6 above m");
    apply(1, 0, 1, 32'h0, 32'h0, 16'h0001, "R6 m one");
    apply(1, 0, 1, 32'h0000_FFFE, 32'h0000_FFFE, 16'hFFFF, "R8 overflow");
    apply(1, 0, 1, 32'h0000_8001, 32'h0000_7FFF, 16'h8003, "R8 carry out");
    apply(1, 1, 1, 32'h0000_0009, 32'h0000_0004, 16'h000B, "R7 no borrow");
    apply(1, 1, 1, 32'h0000_0002, 32'h0000_0007, 16'h000B, "R7 borrow");
    apply(1, 1, 1, 32'h0000_0123, 32'h0000_0123, 16'h0200, "R7 equal");
    apply(1, 1, 1, 32'h0000_0000, 32'h0000_FFFE, 16'hFFFF, "R7 max");
    // random patterns
    for (int i = 0; i < 300; i++) begin
      apply(0, 1'($urandom), 1'($urandom), DW'($urandom), DW'($urandom),
            R'($urandom), "R1 R2 random");
      apply(1, 1'($urandom), 0, DW'($urandom), DW'($urandom), R'($urandom),
            "R3 R4 random");
    end
    for (int i = 0; i < 300; i++) begin
      int unsigned mm;
      mm = $urandom_range(65535, 1);
      apply(1, 1'($urandom), 1, DW'($urandom % mm), DW'($urandom % mm), R'(mm),
            "R6 R7 R8 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule